// File: doc/BRIEF.md
# Two-Channel PWM Register Controller

This block is the register front end and waveform path of a two-channel PWM peripheral. A simple 32-bit register bus (write strobe, read strobe, byte address, write data, registered read data) programs, per channel, a four-bit control nibble, a 16-bit frequency control word, an 8-bit on-time and an 8-bit period. Every register reads back.

Each channel has a variable-frequency generator: a 16-bit phase accumulator that adds the control word every clock, with the accumulator MSB as the raw waveform. A power-of-two control word gives a clean 50% square wave. Each rising edge of that waveform advances a constant-frequency PWM stage, which counts from 0 to the period value and stays high while its count is below the on-time. A select bit picks which of the two waveforms goes to the channel's pad model. The pad model applies force-high, open-drain and an active-low output enable, and drives a registered output bit and a registered drive-enable bit.

Software enables a channel by writing its nibble with run set, open-drain set and the enable-bar bit cleared. It disables the channel by writing the opposite values.

Top module: `pwm_ctl_top`

## Requirements
- R1: After a synchronous reset, the control register at 0x00 reads 0x00000022, so both enable-bar bits are 1 and all other bits are 0. Every other register reads 0, and both `pad_oe` bits are 0.
- R2: Registers are word-aligned.
  - Control (0x00) holds channel c's nibble at bits 4c..4c+3: bit 4c is run, 4c+1 is output-enable-bar, 4c+2 is force-high, 4c+3 is open-drain.
  - Select (0x04) holds channel c's select bit at bit 4c.
  - Control-word high byte is at 0x08+8c and low byte at 0x0C+8c.
  - On-time is at 0x18+8c and period at 0x1C+8c.
  - Writes take write-data bits 7:0 for byte registers. Unused bits read as 0.
  - Read data appears on `bus_rdata` the cycle after `bus_rd` and holds until the next read.
- R3: A write to an unmapped or misaligned address changes no register. A read from such an address returns 0.
- R4: While run is 1, the channel's 16-bit accumulator adds the control word every clock, and the raw waveform is accumulator bit 15. While run is 0, the accumulator is held at 0 and the channel's run-gated level is 0.
- R5: The PWM counter advances on each 0-to-1 transition of the raw waveform and wraps to 0 after reaching the period value. The PWM waveform is 1 while the count is below the on-time: on-time 0 gives constant 0, and on-time above the period gives constant 1.
- R6: A select bit of 1 routes the PWM waveform to the pad, and 0 routes the raw waveform. The two channels are independent.
- R7: Force-high makes the pad level 1 regardless of run and select.
- R8: With output-enable-bar at 1, `pad_oe` is 0 and `pad_out` is 0.
- R9: With output-enable-bar at 0 and open-drain at 1, `pad_out` is 0 and `pad_oe` is the inverse of the level. With open-drain at 0, `pad_oe` is 1 and `pad_out` is the level.
- R10: Pad outputs are registered. A configuration write at clock edge t changes the pads at edge t+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_out | output | 2 | Per-channel pad data |
| pad_oe | output | 2 | Per-channel pad drive enable |

## Verification
A corrupted accumulator or counter shows up within one waveform period as a shifted edge or a wrong high-time on `pad_out`. A wrong control bit shows up on `pad_oe` or `pad_out` one clock after the write. A decode error shows up on `bus_rdata` one clock after a read. The bench's behavioural model tracks the registers, accumulators, counters and pads, and compares both pads and read data on every cycle, so any of these faults is caught within a few clocks of becoming visible.

// File: rtl/pwm_ctl_pkg.sv
package pwm_ctl_pkg;
  localparam int NCH    = 2;
  localparam int CW_W   = 16;
  localparam int TW     = 8;
  localparam int BYTE   = 8;
  localparam int AW     = 6;
  localparam int DW     = 32;
  localparam int NIB    = 4;
  localparam int STRIDE = 8;
  // byte offsets
  localparam int A_CTRL = 'h00;
  localparam int A_SEL  = 'h04;
  localparam int A_CWHI = 'h08;
  localparam int A_CWLO = 'h0C;
  localparam int A_ON   = 'h18;
  localparam int A_PER  = 'h1C;
  localparam int A_LAST = A_PER + STRIDE * (NCH - 1);
  // nibble bit positions
  localparam int B_RUN   = 0;
  localparam int B_OEN   = 1;
  localparam int B_FORCE = 2;
  localparam int B_OD    = 3;
  localparam logic [NIB-1:0] RST_NIB = 4'b0010;

  typedef struct packed {
    logic            run;
    logic            oe_n;
    logic            force_hi;
    logic            open_drain;
    logic            use_pwm;
    logic [CW_W-1:0] cword;
    logic [TW-1:0]   on_t;
    logic [TW-1:0]   period;
  } chan_cfg_t;
endpackage

// File: rtl/pwm_ctl_regs.sv
module pwm_ctl_regs
  import pwm_ctl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [AW-1:0]         addr,
  input  logic [DW-1:0]         wdata,
  output logic [DW-1:0]         rdata,
  output chan_cfg_t [NCH-1:0]   cfg
);
  logic [NIB-1:0]  nib    [NCH];
  logic            sel    [NCH];
  logic [CW_W-1:0] cw     [NCH];
  logic [TW-1:0]   on_r   [NCH];
  logic [TW-1:0]   per_r  [NCH];
  logic [DW-1:0]   rd_mux;
  logic            unused_wbits;

  assign unused_wbits = ^wdata[DW-1:NIB*NCH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        nib[c]   <= RST_NIB;
        sel[c]   <= 1'b0;
        cw[c]    <= '0;
        on_r[c]  <= '0;
        per_r[c] <= '0;
      end
      rdata <= '0;
    end else begin
      if (wr_en) begin
        for (int c = 0; c < NCH; c++) begin
          if (addr == AW'(A_CTRL))              nib[c]               <= wdata[NIB*c +: NIB];
          if (addr == AW'(A_SEL))               sel[c]               <= wdata[NIB*c];
          if (addr == AW'(A_CWHI + STRIDE*c))   cw[c][BYTE +: BYTE]  <= wdata[BYTE-1:0];
          if (addr == AW'(A_CWLO + STRIDE*c))   cw[c][0 +: BYTE]     <= wdata[BYTE-1:0];
          if (addr == AW'(A_ON + STRIDE*c))     on_r[c]              <= wdata[TW-1:0];
          if (addr == AW'(A_PER + STRIDE*c))    per_r[c]             <= wdata[TW-1:0];
        end
      end
      if (rd_en) rdata <= rd_mux;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NCH; c++) begin
      if (addr == AW'(A_CTRL))            rd_mux[NIB*c +: NIB] = nib[c];
      if (addr == AW'(A_SEL))             rd_mux[NIB*c]        = sel[c];
      if (addr == AW'(A_CWHI + STRIDE*c)) rd_mux[BYTE-1:0]     = cw[c][BYTE +: BYTE];
      if (addr == AW'(A_CWLO + STRIDE*c)) rd_mux[BYTE-1:0]     = cw[c][0 +: BYTE];
      if (addr == AW'(A_ON + STRIDE*c))   rd_mux[TW-1:0]       = on_r[c];
      if (addr == AW'(A_PER + STRIDE*c))  rd_mux[TW-1:0]       = per_r[c];
    end
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      cfg[c].run        = nib[c][B_RUN];
      cfg[c].oe_n       = nib[c][B_OEN];
      cfg[c].force_hi   = nib[c][B_FORCE];
      cfg[c].open_drain = nib[c][B_OD];
      cfg[c].use_pwm    = sel[c];
      cfg[c].cword      = cw[c];
      cfg[c].on_t       = on_r[c];
      cfg[c].period     = per_r[c];
    end
  end

  // R3: reads beyond the map return zero
  a_r3_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr > AW'(A_LAST)) |=> rdata == '0);
  // R2: read data holds between reads
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/pwm_ctl_vfg.sv
module pwm_ctl_vfg #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [CW-1:0] cword,
  output logic          wave,
  output logic          tick
);
  logic [CW-1:0] acc;
  logic          prev_msb;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      acc      <= '0;
      prev_msb <= 1'b0;
    end else begin
      acc      <= acc + cword;
      prev_msb <= acc[CW-1];
    end
  end

  assign wave = acc[CW-1];
  assign tick = acc[CW-1] & ~prev_msb;

  // R4: accumulator advances by the control word while running
  a_r4_acc_step: assert property (@(posedge clk) disable iff (rst)
    run |=> acc == CW'($past(acc) + $past(cword)));
  // R4: stopped channel holds zero
  a_r4_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !run |=> (acc == '0 && !wave));
endmodule

// File: rtl/pwm_ctl_duty.sv
module pwm_ctl_duty #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          tick,
  input  logic [TW-1:0] on_t,
  input  logic [TW-1:0] period,
  output logic          wave
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (tick)    cnt <= (cnt >= period) ? '0 : cnt + TW'(1);
  end

  assign wave = (cnt < on_t);

  // R5: count moves only on a raw-waveform rising edge
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> $stable(cnt));
  // R5: wrap after the period value
  a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
    (run && tick && cnt >= period) |=> cnt == '0);
endmodule

// File: rtl/pwm_ctl_pad.sv
module pwm_ctl_pad (
  input  logic clk,
  input  logic rst,
  input  logic oe_n,
  input  logic force_hi,
  input  logic open_drain,
  input  logic level_in,
  output logic pad_o,
  output logic pad_oe
);
  logic level;
  assign level = force_hi | level_in;

  always_ff @(posedge clk) begin
    if (rst || oe_n) begin
      pad_o  <= 1'b0;
      pad_oe <= 1'b0;
    end else if (open_drain) begin
      pad_o  <= 1'b0;
      pad_oe <= ~level;
    end else begin
      pad_o  <= level;
      pad_oe <= 1'b1;
    end
  end

  a_r8_tristate: assert property (@(posedge clk) disable iff (rst)
    oe_n |=> (!pad_oe && !pad_o));
  a_r9_od_never_high: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && open_drain) |=> !pad_o);
  a_r7_force_high: assert property (@(posedge clk) disable iff (rst)
    (force_hi && !oe_n && !open_drain) |=> (pad_o && pad_oe));
endmodule

// File: rtl/pwm_ctl_top.sv
module pwm_ctl_top
  import pwm_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NCH-1:0]    pad_out,
  output logic [NCH-1:0]    pad_oe
);
  chan_cfg_t [NCH-1:0] cfg;

  pwm_ctl_regs u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr_en (bus_wr),
    .rd_en (bus_rd),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .rdata (bus_rdata),
    .cfg   (cfg)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic vwave, vtick, dwave, lvl;

    pwm_ctl_vfg #(.CW(CW_W)) u_vfg (
      .clk   (clk),
      .rst   (rst),
      .run   (cfg[c].run),
      .cword (cfg[c].cword),
      .wave  (vwave),
      .tick  (vtick)
    );

    pwm_ctl_duty #(.TW(TW)) u_duty (
      .clk    (clk),
      .rst    (rst),
      .run    (cfg[c].run),
      .tick   (vtick),
      .on_t   (cfg[c].on_t),
      .period (cfg[c].period),
      .wave   (dwave)
    );

    assign lvl = cfg[c].run & (cfg[c].use_pwm ? dwave : vwave);

    pwm_ctl_pad u_pad (
      .clk        (clk),
      .rst        (rst),
      .oe_n       (cfg[c].oe_n),
      .force_hi   (cfg[c].force_hi),
      .open_drain (cfg[c].open_drain),
      .level_in   (lvl),
      .pad_o      (pad_out[c]),
      .pad_oe     (pad_oe[c])
    );
  end
endmodule

// File: tb/pwm_ctl_top_tb_top.sv
module pwm_ctl_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  pad_out, pad_oe;

  int checks = 0, errors = 0, cyc = 0;
  bit cmp_en = 0, done = 0;
  string tag = "R1";

  // behavioural reference state
  int m_nib[2], m_sel[2], m_cw[2], m_on[2], m_per[2];
  int m_acc[2], m_prev[2], m_cnt[2], m_o[2], m_oe[2];
  int m_rdata;

  always #2 clk = ~clk;

  pwm_ctl_top dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic int mread(int a);
    int v = 0;
    for (int c = 0; c < 2; c++) begin
      if (a == 0)       v |= m_nib[c] << (4*c);
      if (a == 4)       v |= m_sel[c] << (4*c);
      if (a == 8+8*c)   v = (m_cw[c] >> 8) & 'hFF;
      if (a == 12+8*c)  v = m_cw[c] & 'hFF;
      if (a == 24+8*c)  v = m_on[c];
      if (a == 28+8*c)  v = m_per[c];
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        m_nib[c] = 2; m_sel[c] = 0; m_cw[c] = 0; m_on[c] = 0; m_per[c] = 0;
        m_acc[c] = 0; m_prev[c] = 0; m_cnt[c] = 0; m_o[c] = 0; m_oe[c] = 0;
      end
      m_rdata = 0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        int wv, tk, dw, lvl;
        wv  = (m_acc[c] >> 15) & 1;
        tk  = (wv == 1 && m_prev[c] == 0) ? 1 : 0;
        dw  = (m_cnt[c] < m_on[c]) ? 1 : 0;
        lvl = ((m_nib[c] >> 2) & 1) | ((m_nib[c] & 1) & (m_sel[c] ? dw : wv));
        if ((m_nib[c] >> 1) & 1) begin m_o[c] = 0; m_oe[c] = 0; end
        else if ((m_nib[c] >> 3) & 1) begin m_o[c] = 0; m_oe[c] = 1 - lvl; end
        else begin m_o[c] = lvl; m_oe[c] = 1; end
        if ((m_nib[c] & 1) == 0) begin
          m_acc[c] = 0; m_prev[c] = 0; m_cnt[c] = 0;
        end else begin
          if (tk) m_cnt[c] = (m_cnt[c] >= m_per[c]) ? 0 : m_cnt[c] + 1;
          m_prev[c] = wv;
          m_acc[c]  = (m_acc[c] + m_cw[c]) & 'hFFFF;
        end
      end
      if (bus_rd) m_rdata = mread(int'(bus_addr));
      if (bus_wr) begin
        int a, d;
        a = int'(bus_addr); d = int'(bus_wdata);
        for (int c = 0; c < 2; c++) begin
          if (a == 0)      m_nib[c] = (d >> (4*c)) & 'hF;
          if (a == 4)      m_sel[c] = (d >> (4*c)) & 1;
          if (a == 8+8*c)  m_cw[c] = (m_cw[c] & 'hFF) | ((d & 'hFF) << 8);
          if (a == 12+8*c) m_cw[c] = (m_cw[c] & 'hFF00) | (d & 'hFF);
          if (a == 24+8*c) m_on[c] = d & 'hFF;
          if (a == 28+8*c) m_per[c] = d & 'hFF;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", t, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (cmp_en && !rst && !done) begin
      for (int c = 0; c < 2; c++) begin
        chk(pad_out[c] == m_o[c][0], {tag, " pad_out"}, pad_out[c], m_o[c]);
        chk(pad_oe[c] == m_oe[c][0], {tag, " pad_oe"}, pad_oe[c], m_oe[c]);
      end
      chk(bus_rdata == m_rdata, "R2 readback", bus_rdata, m_rdata);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = 32'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, input int exp, input string t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 6'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    chk(bus_rdata == 32'(exp), t, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic high_count(input int c, input int n, input int exp, input string t);
    int hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hi += int'(pad_out[c]);
    end
    chk(hi == exp, t, hi, exp);
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    cmp_en = 1'b1;
    // R1 reset state
    tag = "R1";
    chk(pad_oe == 2'b00, "R1 pad_oe after reset", pad_oe, 0);
    rd('h00, 'h22, "R1 control reset");
    rd('h04, 0, "R1 select reset");
    rd('h1C, 0, "R1 period reset");

    // R2 map and field widths
    tag = "R2";
    wr('h08, 'h1ABC); rd('h08, 'hBC, "R2 cword hi byte ch0");
    wr('h14, 'h55);   rd('h14, 'h55, "R2 cword lo byte ch1");
    wr('h20, 'h1F7);  rd('h20, 'hF7, "R2 on-time ch1");
    wr('h00, -1);     rd('h00, 'hFF, "R2 control nibbles");
    wr('h04, -1);     rd('h04, 'h11, "R2 select bits");
    wr('h00, 'h22);   wr('h04, 0);

    // R3 unmapped and misaligned addresses
    tag = "R3";
    wr('h28, -1); wr('h3C, -1); wr('h02, -1); wr('h09, -1);
    rd('h00, 'h22, "R3 control unchanged");
    rd('h08, 'hBC, "R3 cword unchanged");
    rd('h28, 0, "R3 unmapped read zero");
    rd('h01, 0, "R3 misaligned read zero");

    // R4 raw waveform, cword 0x4000 gives 50% duty
    tag = "R4";
    wr('h08, 'h40); wr('h0C, 0); wr('h00, 'h21);
    idle(10);
    high_count(0, 64, 32, "R4 raw 50% duty");

    // R5 and R6: PWM stage selected on ch0
    tag = "R5 R6";
    wr('h08, 'h80); wr('h18, 3); wr('h1C, 4); wr('h04, 'h01);
    idle(20);
    high_count(0, 100, 60, "R5 on=3 period=4");
    wr('h18, 'hFF); wr('h1C, 'h10);
    idle(4);
    high_count(0, 50, 50, "R5 on above period");
    wr('h18, 0);
    idle(4);
    high_count(0, 50, 0, "R5 on zero");

    // R6 second channel concurrently on raw waveform
    tag = "R6";
    wr('h18, 2); wr('h1C, 5);
    wr('h10, 'h20); wr('h14, 0); wr('h00, 'h11);
    idle(150);

    // R4 stop: run cleared, enabled pad drives 0
    tag = "R4 stop";
    wr('h00, 'h22); wr('h04, 0); wr('h00, 'h20);
    idle(2);
    chk(pad_out[0] == 1'b0 && pad_oe[0] == 1'b1, "R4 stopped level", {pad_oe[0], pad_out[0]}, 2);

    // R7 force high without run
    tag = "R7";
    wr('h00, 'h24);
    idle(1);
    chk(pad_out[0] == 1'b1, "R7 force high", pad_out[0], 1);

    // R8 tri-state with force still set
    tag = "R8";
    wr('h00, 'h26);
    idle(1);
    chk(pad_oe[0] == 1'b0 && pad_out[0] == 1'b0, "R8 tristate", {pad_oe[0], pad_out[0]}, 0);

    // R9 open-drain
    tag = "R9";
    wr('h00, 'h2C);
    idle(1);
    chk(pad_oe[0] == 1'b0 && pad_out[0] == 1'b0, "R9 od released on high", {pad_oe[0], pad_out[0]}, 0);
    wr('h00, 'h28);
    idle(1);
    chk(pad_oe[0] == 1'b1 && pad_out[0] == 1'b0, "R9 od drives low", {pad_oe[0], pad_out[0]}, 2);

    // R10 one-cycle latency from write to pad
    tag = "R10";
    wr('h00, 'h24);
    chk(pad_out[0] == 1'b0, "R10 pad unchanged at write edge", pad_out[0], 0);
    @(negedge clk);
    chk(pad_out[0] == 1'b1, "R10 pad updated next edge", pad_out[0], 1);

    // enable both channels, open-drain on ch0, PWM on ch1
    tag = "R9 R6 enable";
    wr('h18, 1); wr('h1C, 2); wr('h04, 'h10);
    wr('h20, 2); wr('h24, 5); wr('h08, 'h80);
    wr('h00, 'h19);
    idle(200);

    // R1 reset during operation
    tag = "R1";
    @(negedge clk); rst = 1'b1;
    idle(2);
    rst = 1'b0;
    chk(pad_oe == 2'b00, "R1 pads after reset", pad_oe, 0);
    rd('h00, 'h22, "R1 control after reset");
    rd('h24, 0, "R1 period ch1 after reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule